// File: doc/BRIEF.md
# Cipher Block Transfer Window

This block sits between a 32-bit host bus and a cipher core that works on 128-bit blocks. It exposes two small windows of four words each. The data window is split by direction: host writes fill an input buffer that feeds the core, and host reads at the same word addresses return the output buffer the core last completed. A block may be moved as four separate word accesses, and any other host accesses may fall between them.

The tag window returns the authentication tag captured at the end of an operation. While the core is busy this window reads as zero. When the last operation produced no tag, or once the tag has been read out, the window shows the live IV words. The tag counts as read once its last word has been read. A host that needs both values must therefore read the tag first. If it reads them the other way round, it gets the IV twice.

Top module: `cxb_window`

Address map (word addressed, 3 bits): bit 2 picks the window (0 = data, 1 = tag). Bits [1:0] pick the word. Word n occupies bits [32n+31:32n] of every 128-bit block.

## Requirements
- R1: After reset, `in_full` and `host_rvalid` are 0, data-window reads return 0, and tag-window reads return the IV.
- R2: A host write to data word n loads bits [32n+31:32n] of `in_block`. Reads of the data window never return the input buffer.
- R3: `in_full` rises only once all four data word positions have been written since the last `core_start`, in any order. A word written twice counts once.
- R4: `in_full` is 0 in the cycle after `core_start`.
- R5: A `core_done` pulse captures `core_result`, and later data-window reads of word n return word n of that result.
- R6: Read data and `host_rvalid` appear exactly one cycle after `host_re`.
- R7: Tag-window reads while `core_busy` is 1 return zero and do not consume the tag.
- R8: If the last operation reported no tag (`core_tag_valid` = 0 at `core_done`), tag-window reads return the live `core_iv` word.
- R9: If a tag was reported, tag-window reads return tag words until tag word 3 has been read. After that they return IV words, so reading word 3 first makes the later reads of words 0 to 2 return the IV.
- R10: Host writes to the tag window change neither `in_block` nor `in_full`.
- R11: Host reads and tag-window writes placed between data writes do not disturb the count of written words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | 3 | Window select and word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after host_re |
| core_start | input | 1 | Core accepts the input block |
| core_busy | input | 1 | Core is processing |
| core_done | input | 1 | One-cycle pulse when the result is ready |
| core_result | input | 128 | Result block from the core |
| core_tag | input | 128 | Tag from the core |
| core_tag_valid | input | 1 | Operation produced a tag, sampled with core_done |
| core_iv | input | 128 | Current IV from the core |
| in_block | output | 128 | Input buffer contents |
| in_full | output | 1 | All four input words written since last start |

## Verification
The hardest state to reach is a pending tag that is only partly read out. This state can be reached through a read taken while the core is busy, or through a read of the last tag word ahead of the others. The bench gets there by pulsing `core_done` with a tag and then issuing tag reads in reverse and in busy-gated orders. The IV and tag patterns are distinct, so every later read shows whether the tag was consumed. The fill logic is swept over all fifteen non-empty subsets of written words.

// File: rtl/cxb_pkg.sv
package cxb_pkg;
  typedef enum logic {WIN_DATA = 1'b0, WIN_TAG = 1'b1} win_e;
endpackage

// File: rtl/cxb_in_collect.sv
module cxb_in_collect #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic                    start,
  output logic [WORDS*WORD_W-1:0] block,
  output logic                    full
);
  logic [WORD_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  seen_q, seen_nx;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_comb begin
    seen_nx = seen_q;
    if (wr_en) seen_nx[wr_idx] = 1'b1;
    if (start) seen_nx = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      full   <= 1'b0;
    end else begin
      seen_q <= seen_nx;
      full   <= &seen_nx;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_pack
    assign block[g*WORD_W +: WORD_W] = mem[g];
  end

  // R4: a start empties the collector
  p_full_clear_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> !full);
  // R3: the flag can only rise on a write
  p_full_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(wr_en));
endmodule

// File: rtl/cxb_result_hold.sv
module cxb_result_hold #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BLK_W = WORDS*WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic [BLK_W-1:0] result,
  input  logic [BLK_W-1:0] tag,
  input  logic             tag_valid,
  input  logic             consume,
  output logic [BLK_W-1:0] out_blk,
  output logic [BLK_W-1:0] tag_blk,
  output logic             tag_pend
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_blk  <= '0;
      tag_blk  <= '0;
      tag_pend <= 1'b0;
    end else if (done) begin
      out_blk  <= result;
      tag_blk  <= tag;
      tag_pend <= tag_valid;
    end else if (consume) begin
      tag_pend <= 1'b0;
    end
  end

  // R5: completion captures the core result
  p_done_capture_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> out_blk == $past(result));
  // R9: the tag is released by reading its last word
  p_tag_consume_r9: assert property (@(posedge clk) disable iff (rst)
    (consume && !done) |=> !tag_pend);
endmodule

// File: rtl/cxb_rd_mux.sv
module cxb_rd_mux #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BLK_W = WORDS*WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              re,
  input  cxb_pkg::win_e     win,
  input  logic [IDX_W-1:0]  idx,
  input  logic              busy,
  input  logic              tag_pend,
  input  logic [BLK_W-1:0]  out_blk,
  input  logic [BLK_W-1:0]  tag_blk,
  input  logic [BLK_W-1:0]  iv,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid
);
  logic [WORD_W-1:0] word_nx;

  always_comb begin
    if (win == cxb_pkg::WIN_DATA)  word_nx = out_blk[idx*WORD_W +: WORD_W];
    else if (busy)                 word_nx = '0;
    else if (tag_pend)             word_nx = tag_blk[idx*WORD_W +: WORD_W];
    else                           word_nx = iv[idx*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= word_nx;
    end
  end

  // R6: one-cycle read latency
  p_rd_latency_r6: assert property (@(posedge clk) disable iff (rst)
    re |=> rvalid);
  // R7: tag window gated to zero while busy
  p_busy_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (re && busy && win == cxb_pkg::WIN_TAG) |=> rdata == '0);
endmodule

// File: rtl/cxb_window.sv
module cxb_window #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int ADDR_W = IDX_W + 1,
  localparam int BLK_W  = WORDS*WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              core_start,
  input  logic              core_busy,
  input  logic              core_done,
  input  logic [BLK_W-1:0]  core_result,
  input  logic [BLK_W-1:0]  core_tag,
  input  logic              core_tag_valid,
  input  logic [BLK_W-1:0]  core_iv,
  output logic [BLK_W-1:0]  in_block,
  output logic              in_full
);
  cxb_pkg::win_e    win;
  logic [IDX_W-1:0] idx;
  logic             data_wr, consume, tag_pend;
  logic [BLK_W-1:0] out_blk, tag_blk;

  assign win     = cxb_pkg::win_e'(host_addr[ADDR_W-1]);
  assign idx     = host_addr[IDX_W-1:0];
  assign data_wr = host_we && (win == cxb_pkg::WIN_DATA);
  assign consume = host_re && (win == cxb_pkg::WIN_TAG) && !core_busy
                   && (idx == IDX_W'(WORDS-1)) && tag_pend;

  cxb_in_collect #(.WORD_W(WORD_W), .WORDS(WORDS)) u_in (
    .clk(clk), .rst(rst), .wr_en(data_wr), .wr_idx(idx), .wr_data(host_wdata),
    .start(core_start), .block(in_block), .full(in_full));

  cxb_result_hold #(.WORD_W(WORD_W), .WORDS(WORDS)) u_hold (
    .clk(clk), .rst(rst), .done(core_done), .result(core_result),
    .tag(core_tag), .tag_valid(core_tag_valid), .consume(consume),
    .out_blk(out_blk), .tag_blk(tag_blk), .tag_pend(tag_pend));

  cxb_rd_mux #(.WORD_W(WORD_W), .WORDS(WORDS)) u_rd (
    .clk(clk), .rst(rst), .re(host_re), .win(win), .idx(idx), .busy(core_busy),
    .tag_pend(tag_pend), .out_blk(out_blk), .tag_blk(tag_blk), .iv(core_iv),
    .rdata(host_rdata), .rvalid(host_rvalid));

  // R10: tag-window writes leave the fill flag alone
  p_tag_wr_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (host_we && win == cxb_pkg::WIN_TAG && !core_start) |=> $stable(in_full));
endmodule

// File: tb/cxb_window_bench.sv
module cxb_window_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic we = 0, re = 0, start = 0, busy = 0, done = 0, tvalid = 0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [127:0] result = '0, tag = '0, iv = '0, blk;
  logic [31:0] rdata;
  logic rvalid, full;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cxb_window u_cxb_window (
    .clk(clk), .rst(rst), .host_we(we), .host_re(re), .host_addr(addr),
    .host_wdata(wdata), .host_rdata(rdata), .host_rvalid(rvalid),
    .core_start(start), .core_busy(busy), .core_done(done),
    .core_result(result), .core_tag(tag), .core_tag_valid(tvalid),
    .core_iv(iv), .in_block(blk), .in_full(full));

  function automatic logic [31:0] pat(int k, int i);
    return 32'(k) * 32'h1000_0000 + 32'(i + 1) * 32'h0101_0101 ^ 32'hC3C3_0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1; addr = a;
    @(negedge clk); re = 0;
    chk("R6 rvalid", 32'(rvalid), 32'd1);
    d = rdata;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R4 full after start", 32'(full), 32'd0);
  endtask

  task automatic finish_op(int k, bit with_tag);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      result[i*32 +: 32] = pat(k, i);
      tag[i*32 +: 32] = pat(k + 7, i);
    end
    tvalid = with_tag; done = 1;
    @(negedge clk); done = 0; tvalid = 0;
  endtask

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 4; i++) iv[i*32 +: 32] = pat(15, i);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 rvalid", 32'(rvalid), 32'd0);
    for (int i = 0; i < 4; i++) begin
      rd(3'(i), d); chk("R1 data zero", d, 32'd0);
      rd(3'(4 + i), d); chk("R1 tag iv", d, pat(15, i));
    end
    @(negedge clk); chk("R6 rvalid drops", 32'(rvalid), 32'd0);
    // R3 / R2 subset sweep
    for (int m = 1; m < 16; m++) begin
      pulse_start();
      for (int i = 0; i < 4; i++)
        if (m[i]) begin
          wr(3'(i), pat(m, i));
          chk("R2 word load", blk[i*32 +: 32], pat(m, i));
        end
      if (m[0]) wr(3'd0, pat(m, 0));  // repeat counts once
      chk("R3 subset", 32'(full), 32'(m == 15));
      for (int i = 0; i < 4; i++) if (!m[i]) wr(3'(i), pat(m, i));
      chk("R3 complete", 32'(full), 32'd1);
    end
    // R10 tag-window writes ignored
    pulse_start();
    for (int i = 0; i < 4; i++) wr(3'(4 + i), 32'hDEAD_0000);
    chk("R10 full", 32'(full), 32'd0);
    for (int i = 0; i < 4; i++) chk("R10 block", blk[i*32 +: 32], pat(15, i));
    // R11 interleaved accesses
    wr(3'd2, pat(20, 2)); rd(3'd1, d);
    wr(3'd0, pat(20, 0)); rd(3'd5, d); wr(3'd6, 32'h0);
    wr(3'd3, pat(20, 3));
    chk("R11 not yet", 32'(full), 32'd0);
    wr(3'd1, pat(20, 1));
    chk("R11 full", 32'(full), 32'd1);
    // R2 reads never see the input buffer
    rd(3'd0, d); chk("R2 read is output", d, 32'd0);
    // R5 / R8 / R9 over several operations
    for (int k = 1; k <= 3; k++) begin
      finish_op(k, k != 2);
      for (int i = 0; i < 4; i++) begin
        rd(3'(i), d); chk("R5 result", d, pat(k, i));
      end
      if (k == 2) begin
        for (int i = 0; i < 4; i++) begin
          rd(3'(4 + i), d); chk("R8 iv no tag", d, pat(15, i));
        end
      end else if (k == 1) begin
        for (int i = 0; i < 4; i++) begin
          rd(3'(4 + i), d); chk("R9 tag", d, pat(k + 7, i));
        end
        rd(3'd4, d); chk("R9 iv after tag", d, pat(15, 0));
      end else begin
        rd(3'd7, d); chk("R9 reverse tag3", d, pat(k + 7, 3));
        for (int i = 0; i < 4; i++) begin
          rd(3'(4 + i), d); chk("R9 reverse iv", d, pat(15, i));
        end
      end
    end
    // R7 busy gating without consuming
    finish_op(4, 1);
    busy = 1;
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), d); chk("R7 busy zero", d, 32'd0);
    end
    busy = 0;
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), d); chk("R7 tag kept", d, pat(11, i));
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule